// File: doc/BRIEF.md
# Masked Interrupt Pending and Status Collector

This block gathers interrupt requests from twenty-three level-sensitive peripheral sources and one emulator source, and presents them to software through four word-addressed registers. One view (pending) shows every active source, enabled or not. The other (status) shows only the sources the mask register lets through. Masked requests therefore stay visible to a polling routine without ever raising the processor interrupt.

The emulator source combines three sub-requests: two breakpoint requests from on-chip debug logic and an external active-low pin that is edge-detected after synchronization. Each sub-request sets a sticky flag in a dedicated flag register, and software clears each flag by writing a 1 to it. The emulator pending bit stays high until all three flags are clear.

The block drives a single interrupt request with a three-bit priority level. The level is the highest fixed level among the active, unmasked sources. Register reads are combinational from a two-bit word index. Writes take effect at the clock edge where the write strobe is high.

Top module: `irq_pend_unit`

## Requirements
- R1: After reset the mask register reads 0x00FFFFFF (every source masked), and the pending, status and emulator flag registers read 0. The interrupt output is low and the level is 0.
- R2: The peripheral pending bit i (0 to 22) follows src_req[i] through a SYNC_STAGES-flop synchronizer. It reads 1 exactly SYNC_STAGES rising edges after the input rises, and it returns to 0 after the input falls, whatever the mask holds.
- R3: The status register (index 2) equals pending AND NOT mask. The mask register (index 0) is read/write, and a mask bit of 1 hides that source from status.
- R4: Bits 31..24 of every register read 0. Writes to the pending (index 1) and status (index 2) registers change nothing.
- R5: A falling edge of emu_pin_n, seen after synchronization, sets flag bit 2 of the emulator flag register (index 3). Holding the pin low, or a rising edge, sets nothing new.
- R6: A high bkpt_req[0] sets flag bit 0 at the next edge, and a high bkpt_req[1] sets flag bit 1.
- R7: Writing index 3 clears each flag whose data bit is 1 and leaves flags whose data bit is 0. Pending bit 23 is the OR of the three flags and falls only when all three are clear.
- R8: If a sub-source sets a flag in the same cycle that software clears it, the flag stays set.
- R9: irq_o is high exactly when status is nonzero. irq_level_o is the highest level among the set status bits, and 0 when none is set. The levels are: bit 23 → 7, bit 19 → 6, bit 20 → 5, bit 18 → 3, bit 17 → 2, bit 16 → 1, and every other bit → 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Word index: 0 mask, 1 pending, 2 status, 3 emulator flags |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| src_req | input | 23 | Level-sensitive peripheral requests, bit i maps to pending bit i |
| bkpt_req | input | 2 | Breakpoint requests from the debug logic |
| emu_pin_n | input | 1 | External emulator request, active low, edge-sensitive |
| irq_o | output | 1 | Interrupt request |
| irq_level_o | output | 3 | Priority level of the request |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This shows that the peripheral pending latency and the pin edge detector both follow the parameter, and it lets the exact-edge check tell a deeper chain from a shorter one. DATA_W stays at 32, so the zero upper byte is observed on every read.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int NUM_SRC   = 24;
  localparam int EMU_BIT   = 23;
  localparam int LVL_W     = 3;
  localparam int EMU_FLAGS = 3;
  localparam int SEL_W     = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_MASK = 2'd0,
    SEL_PEND = 2'd1,
    SEL_STAT = 2'd2,
    SEL_EMU  = 2'd3
  } reg_sel_e;

  // Fixed priority level of each pending bit.
  function automatic logic [LVL_W-1:0] src_level(input int idx);
    logic [LVL_W-1:0] lvl;
    case (idx)
      23:      lvl = 3'd7;
      19:      lvl = 3'd6;
      20:      lvl = 3'd5;
      18:      lvl = 3'd3;
      17:      lvl = 3'd2;
      16:      lvl = 3'd1;
      default: lvl = 3'd4;
    endcase
    return lvl;
  endfunction
endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int WIDTH   = 1,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = din;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        stg_q[s] <= {WIDTH{RST_VAL}};
      end
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        stg_q[s] <= stg_d[s];
      end
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/emu_flag_ctl.sv
module emu_flag_ctl
  import irq_pend_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           bkpt_req,
  input  logic                 pin_n,
  input  logic                 clr_we,
  input  logic [EMU_FLAGS-1:0] clr_bits,
  output logic                 pin_fall,
  output logic [EMU_FLAGS-1:0] flags
);
  logic                 pin_s;
  logic                 pin_prev_q;
  logic [EMU_FLAGS-1:0] flag_q;
  logic [EMU_FLAGS-1:0] flag_d;
  logic [EMU_FLAGS-1:0] set_vec;
  logic [EMU_FLAGS-1:0] clr_vec;

  // The pin idles high, so the chain resets to 1 and no edge is seen at start-up.
  irq_sync_bank #(
    .WIDTH  (1),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_pin_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_n),
    .dout (pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev_q <= 1'b1;
    else        pin_prev_q <= pin_s;
  end

  assign pin_fall = pin_prev_q & ~pin_s;
  assign set_vec  = {pin_fall, bkpt_req};
  assign clr_vec  = clr_we ? clr_bits : '0;

  // A new event wins over a clear in the same cycle.
  always_comb begin
    flag_d = (flag_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags = flag_q;
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick
  import irq_pend_pkg::*;
#(
  parameter int WIDTH = NUM_SRC
) (
  input  logic [WIDTH-1:0] active,
  output logic             any,
  output logic [LVL_W-1:0] level
);
  always_comb begin
    level = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (active[i] && (src_level(i) > level)) level = src_level(i);
    end
  end

  assign any = |active;
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit
  import irq_pend_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [EMU_BIT-1:0] src_req,
  input  logic [1:0]        bkpt_req,
  input  logic              emu_pin_n,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_level_o
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic                 rst_meta_q;
  logic                 rst_core;
  reg_sel_e             sel;
  logic                 mask_we;
  logic                 emu_we;
  logic [NUM_SRC-1:0]   mask_q;
  logic [NUM_SRC-1:0]   mask_d;
  logic [EMU_BIT-1:0]   src_s;
  logic [EMU_FLAGS-1:0] emu_flags;
  logic                 pin_fall;
  logic [NUM_SRC-1:0]   pend_vec;
  logic [NUM_SRC-1:0]   status_vec;
  logic [NUM_SRC-1:0]   rd_vec;
  logic                 unused_wdata_hi;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core   <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core   <= rst_meta_q;
    end
  end

  assign sel     = reg_sel_e'(bus_addr);
  assign mask_we = bus_wr && (sel == SEL_MASK);
  assign emu_we  = bus_wr && (sel == SEL_EMU);

  always_comb begin
    mask_d = mask_q;
    if (mask_we) mask_d = bus_wdata[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core)    mask_q <= '1;
    else if (mask_we) mask_q <= mask_d;
  end

  irq_sync_bank #(
    .WIDTH  (EMU_BIT),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b0)
  ) u_src_sync (
    .clk  (clk),
    .rst_n(rst_core),
    .din  (src_req),
    .dout (src_s)
  );

  emu_flag_ctl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_emu (
    .clk     (clk),
    .rst_n   (rst_core),
    .bkpt_req(bkpt_req),
    .pin_n   (emu_pin_n),
    .clr_we  (emu_we),
    .clr_bits(bus_wdata[EMU_FLAGS-1:0]),
    .pin_fall(pin_fall),
    .flags   (emu_flags)
  );

  assign pend_vec   = {|emu_flags, src_s};
  assign status_vec = pend_vec & ~mask_q;

  irq_level_pick #(
    .WIDTH(NUM_SRC)
  ) u_pick (
    .active(status_vec),
    .any   (irq_o),
    .level (irq_level_o)
  );

  always_comb begin
    case (sel)
      SEL_MASK: rd_vec = mask_q;
      SEL_PEND: rd_vec = pend_vec;
      SEL_STAT: rd_vec = status_vec;
      default:  rd_vec = {{(NUM_SRC-EMU_FLAGS){1'b0}}, emu_flags};
    endcase
  end

  assign bus_rdata       = {{PAD_W{1'b0}}, rd_vec};
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk
  import irq_pend_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 emu_we,
  input logic [EMU_FLAGS-1:0] wdata_lo,
  input logic [1:0]           bkpt_req,
  input logic                 pin_fall,
  input logic [EMU_FLAGS-1:0] emu_flags,
  input logic [NUM_SRC-1:0]   pend_vec,
  input logic [NUM_SRC-1:0]   status_vec,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic                 irq_o,
  input logic [LVL_W-1:0]     irq_level_o
);
  logic [EMU_FLAGS-1:0] set_vec;
  logic [EMU_FLAGS-1:0] clr_vec;
  assign set_vec = {pin_fall, bkpt_req};
  assign clr_vec = emu_we ? wdata_lo : '0;

  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    emu_we |=> ((emu_flags & $past(wdata_lo & ~set_vec)) == '0));

  a_r7_zero_retains: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((emu_flags & $past(emu_flags & ~clr_vec)) == $past(emu_flags & ~clr_vec)));

  a_r6_bkpt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|bkpt_req) |=> ((emu_flags[1:0] & $past(bkpt_req)) == $past(bkpt_req)));

  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_we && wdata_lo[0] && bkpt_req[0]) |=> emu_flags[0]);

  a_r5_flag_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(emu_flags[2]) |-> $past(pin_fall));

  a_r3_status_in_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_vec & ~pend_vec) == '0));

  a_r9_irq_matches_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|status_vec));

  a_r9_level_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o ? (irq_level_o != '0) : (irq_level_o == '0));

  a_r9_emu_top_level: assert property (@(posedge clk) disable iff (!rst_n)
    status_vec[EMU_BIT] |-> (irq_level_o == 3'd7));

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NUM_SRC] == '0);
endmodule

bind irq_pend_unit irq_pend_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core),
  .emu_we     (emu_we),
  .wdata_lo   (bus_wdata[2:0]),
  .bkpt_req   (bkpt_req),
  .pin_fall   (pin_fall),
  .emu_flags  (emu_flags),
  .pend_vec   (pend_vec),
  .status_vec (status_vec),
  .bus_rdata  (bus_rdata),
  .irq_o      (irq_o),
  .irq_level_o(irq_level_o)
);

// File: tb/sim_irq_pend_unit.sv
`timescale 1ns/100ps
module sim_irq_pend_unit;
  localparam int STG = 3;

  typedef struct packed {
    logic        is_irq;
    logic [31:0] exp;
  } exp_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [22:0] src_req = '0;
  logic [1:0]  bkpt_req = 2'b00;
  logic        emu_pin_n = 1'b1;
  logic        irq_o;
  logic [2:0]  irq_level_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_item_t exp_q[$];
  string     tag_q[$];
  event      smp_ev;

  always #2 clk = ~clk;

  irq_pend_unit #(.SYNC_STAGES(STG), .DATA_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
    .bkpt_req(bkpt_req), .emu_pin_n(emu_pin_n), .irq_o(irq_o),
    .irq_level_o(irq_level_o)
  );

  // Monitor: pops one expected item per sample event and compares.
  initial begin
    forever begin
      @(smp_ev);
      while (exp_q.size() > 0) begin
        exp_item_t it;
        string     tg;
        logic [31:0] act;
        it = exp_q.pop_front();
        tg = tag_q.pop_front();
        act = it.is_irq ? {28'd0, irq_o, irq_level_o} : bus_rdata;
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s actual=0x%08h expected=0x%08h", tg, act, it.exp);
        end
      end
    end
  end

  task automatic bus_put(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: pushes the expected read value, samples mid-phase, ends on a negedge.
  task automatic exp_rd(input logic [1:0] a, input logic [31:0] e, input string tg);
    exp_item_t it;
    bus_addr = a;
    it.is_irq = 1'b0; it.exp = e;
    exp_q.push_back(it); tag_q.push_back(tg);
    #0.5 -> smp_ev;
    @(negedge clk);
  endtask

  task automatic exp_irq(input logic on, input logic [2:0] lvl, input string tg);
    exp_item_t it;
    it.is_irq = 1'b1; it.exp = {28'd0, on, lvl};
    exp_q.push_back(it); tag_q.push_back(tg);
    #0.5 -> smp_ev;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(5);

    // R1 reset values
    exp_rd(2'd0, 32'h00FF_FFFF, "R1 mask reset");
    exp_rd(2'd1, 32'h0, "R1 pending reset");
    exp_rd(2'd2, 32'h0, "R1 status reset");
    exp_rd(2'd3, 32'h0, "R1 emu flags reset");
    exp_irq(1'b0, 3'd0, "R1 irq idle");

    // R2 exact synchronizer latency, source masked
    bus_addr = 2'd1;
    src_req[5] = 1'b1;
    idle(STG - 1);
    exp_rd(2'd1, 32'h0, "R2 pending before last stage");
    exp_rd(2'd1, 32'h0000_0020, "R2 pending after stages");
    exp_rd(2'd2, 32'h0, "R3 masked source hidden");
    exp_irq(1'b0, 3'd0, "R9 masked no irq");

    // R3/R4 unmask bit 5, upper bits read zero
    bus_put(2'd0, 32'hFFFF_FFDF);
    exp_rd(2'd0, 32'h00FF_FFDF, "R4 mask upper zero");
    exp_rd(2'd2, 32'h0000_0020, "R3 unmasked in status");
    exp_irq(1'b1, 3'd4, "R9 default level");

    // R9 levels of external request lines
    src_req[19] = 1'b1; src_req[16] = 1'b1;
    idle(STG + 2);
    exp_rd(2'd1, 32'h0009_0020, "R2 masked sources pending");
    exp_rd(2'd2, 32'h0000_0020, "R3 still masked");
    bus_put(2'd0, 32'h00FE_FFDF);
    exp_rd(2'd2, 32'h0001_0020, "R3 bit16 unmasked");
    exp_irq(1'b1, 3'd4, "R9 max of 4 and 1");
    bus_put(2'd0, 32'h00F6_FFDF);
    exp_irq(1'b1, 3'd6, "R9 level six wins");

    // R4 writes to read-only registers
    bus_put(2'd1, 32'hFFFF_FFFF);
    bus_put(2'd2, 32'h0);
    exp_rd(2'd1, 32'h0009_0020, "R4 pending write ignored");
    exp_rd(2'd2, 32'h0009_0020, "R4 status write ignored");

    // R2 request drop
    src_req[5] = 1'b0;
    idle(STG + 2);
    exp_rd(2'd1, 32'h0009_0000, "R2 pending follows drop");

    // R5 pin falling edge
    emu_pin_n = 1'b0;
    idle(STG + 4);
    exp_rd(2'd3, 32'h4, "R5 pin edge flag");
    exp_rd(2'd1, 32'h0089_0000, "R7 emu pending bit");
    exp_irq(1'b1, 3'd6, "R9 emu masked");
    bus_put(2'd0, 32'h0076_FFDF);
    exp_irq(1'b1, 3'd7, "R9 emu level seven");

    emu_pin_n = 1'b1;
    idle(STG + 4);
    exp_rd(2'd3, 32'h4, "R5 rising edge no change");
    bus_put(2'd3, 32'h3);
    exp_rd(2'd3, 32'h4, "R7 zero bit leaves flag");

    // R6 breakpoint pulses
    bkpt_req = 2'b01; idle(1); bkpt_req = 2'b00;
    exp_rd(2'd3, 32'h5, "R6 bkpt0 flag");
    bkpt_req = 2'b10; idle(1); bkpt_req = 2'b00;
    exp_rd(2'd3, 32'h7, "R6 bkpt1 flag");

    // R7 individual clears
    bus_put(2'd3, 32'h4);
    exp_rd(2'd3, 32'h3, "R7 clear pin flag");
    exp_rd(2'd1, 32'h0089_0000, "R7 emu bit held by others");
    bus_put(2'd3, 32'h1);
    exp_rd(2'd3, 32'h2, "R7 clear bkpt0 flag");
    bus_put(2'd3, 32'h2);
    exp_rd(2'd3, 32'h0, "R7 all clear");
    exp_rd(2'd1, 32'h0009_0000, "R7 emu bit falls");
    exp_irq(1'b1, 3'd6, "R9 back to six");

    // R8 set beats clear
    bkpt_req = 2'b01;
    idle(1);
    bus_put(2'd3, 32'h1);
    exp_rd(2'd3, 32'h1, "R8 set beats clear");
    bkpt_req = 2'b00;
    bus_put(2'd3, 32'h1);
    exp_rd(2'd3, 32'h0, "R8 clear after release");

    // R5 held low does not retrigger
    emu_pin_n = 1'b0;
    idle(STG + 4);
    bus_put(2'd3, 32'h4);
    idle(STG + 4);
    exp_rd(2'd3, 32'h0, "R5 held low no retrigger");
    emu_pin_n = 1'b1;
    idle(STG + 4);
    emu_pin_n = 1'b0;
    idle(STG + 4);
    exp_rd(2'd3, 32'h4, "R5 second edge");

    // R9 all masked
    bus_put(2'd0, 32'hFFFF_FFFF);
    exp_rd(2'd2, 32'h0, "R3 all masked status");
    exp_irq(1'b0, 3'd0, "R9 all masked idle");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule